// File: doc/BRIEF.md
# Inter-board link port gating

This block sits between a trigger processor and the word-level serializer/deserializer interfaces of eleven inter-board links. Each link has a mask control and a sync control. The block decides, link by link, whether received words reach the trigger logic. It also decides whether the link transmits real payload or one of two fixed 16-bit idle words. Because the two idle words differ, the far end can tell which control is still set.

Both controls are level inputs. The block samples them only on a word boundary strobe, so a control change never cuts a word in half. The transmit word is registered at that same boundary. A per-link status bit reports whether the link is in use, and it can drive a display. Links are indexed 0..7 for the eight board links, and 8, 9 and 10 for the three system interconnect links.

Top module: `link_port_gate`

## Requirements
- R1: After reset every link is masked with sync off. Every transmit lane carries 0xFF00, every status bit is low and no received word is forwarded.
- R2: The mask and sync controls, and the transmit word, change only at a clock edge where `word_stb` is high. A change of `cfg_mask`, `cfg_sync` or `tx_payload` without a strobe has no effect at the ports.
- R3: While a link is masked, its forwarded valid is low and its forwarded data is 0x0000, whatever arrives on the receive side.
- R4: While a link is unmasked, a received word with its valid high appears on the forwarded outputs one clock later. This holds whether sync is on or off.
- R5: A link whose sync control is on transmits 0x00FF. This takes precedence over the mask.
- R6: A link that is masked with sync off transmits 0xFF00.
- R7: A link with mask clear and sync off transmits the payload sampled at the last strobe, and holds it until the next strobe.
- R8: The status bit of a link is high exactly when the link's active mask is clear and its active sync is off.
- R9: Each link is controlled only by its own bit of `cfg_mask` and `cfg_sync`. Bit i belongs to lane i, which occupies bits [16*i+15:16*i] of the flat word buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | Word boundary; controls and transmit word load here |
| cfg_mask | input | 11 | Requested mask, one bit per link |
| cfg_sync | input | 11 | Requested sync, one bit per link |
| tx_payload | input | 176 | Payload words from trigger logic, 16 bits per link |
| rx_word | input | 176 | Words from the deserializers, 16 bits per link |
| rx_valid | input | 11 | Per-link received word valid |
| tx_word | output | 176 | Words to the serializers |
| rx_out_word | output | 176 | Forwarded received words |
| rx_out_valid | output | 11 | Forwarded valid |
| link_active | output | 11 | Per-link in-use status |

## Verification
A mask bit stuck or loaded from the wrong lane shows up in two places. From the strobe edge on, the transmit lane carries a wrong idle word or payload, and the status bit is wrong. Starting one clock later, a received word is wrongly dropped or forwarded. A control register that loads without a strobe changes `tx_word` or `link_active` in the cycle after the stray edge. A swapped priority between the two idle words is visible only on lanes that have both controls set. The stimulus therefore mixes lanes with all four control combinations in one word.

// File: rtl/link_port_gate_pkg.sv
package link_port_gate_pkg;
  localparam int unsigned LPG_WORD_W = 16;
  localparam logic [LPG_WORD_W-1:0] LPG_SYNC_IDLE = 16'h00FF;
  localparam logic [LPG_WORD_W-1:0] LPG_MASK_IDLE = 16'hFF00;
endpackage

// File: rtl/lpg_ctrl.sv
module lpg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic word_stb,
  input  logic cfg_mask,
  input  logic cfg_sync,
  output logic mask_act,
  output logic sync_act
);
  logic mask_nx, sync_nx;

  always_comb begin
    mask_nx = mask_act;
    sync_nx = sync_act;
    if (word_stb) begin
      mask_nx = cfg_mask;
      sync_nx = cfg_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_act <= 1'b1;
      sync_act <= 1'b0;
    end else begin
      mask_act <= mask_nx;
      sync_act <= sync_nx;
    end
  end
endmodule

// File: rtl/lpg_tx.sv
module lpg_tx #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SYNC_PAT = '0,
  parameter logic [W-1:0] MASK_PAT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_stb,
  input  logic         cfg_mask,
  input  logic         cfg_sync,
  input  logic [W-1:0] payload,
  output logic [W-1:0] tx_q
);
  logic [W-1:0] sel_word;
  logic [W-1:0] tx_nx;

  always_comb begin
    if (cfg_sync)      sel_word = SYNC_PAT;
    else if (cfg_mask) sel_word = MASK_PAT;
    else               sel_word = payload;
    tx_nx = word_stb ? sel_word : tx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= MASK_PAT;
    else        tx_q <= tx_nx;
  end
endmodule

// File: rtl/lpg_rx.sv
module lpg_rx #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_act,
  input  logic [W-1:0] rx_word,
  input  logic         rx_valid,
  output logic [W-1:0] out_word,
  output logic         out_valid
);
  logic         accept;
  logic [W-1:0] word_nx;

  always_comb begin
    accept  = rx_valid & ~mask_act;
    word_nx = accept ? rx_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_word  <= word_nx;
      out_valid <= accept;
    end
  end
endmodule

// File: rtl/link_port_gate.sv
module link_port_gate
  import link_port_gate_pkg::*;
#(
  parameter int unsigned N_LINKS = 11,
  parameter int unsigned WORD_W  = LPG_WORD_W,
  parameter logic [WORD_W-1:0] SYNC_PAT = LPG_SYNC_IDLE,
  parameter logic [WORD_W-1:0] MASK_PAT = LPG_MASK_IDLE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      word_stb,
  input  logic [N_LINKS-1:0]        cfg_mask,
  input  logic [N_LINKS-1:0]        cfg_sync,
  input  logic [N_LINKS*WORD_W-1:0] tx_payload,
  input  logic [N_LINKS*WORD_W-1:0] rx_word,
  input  logic [N_LINKS-1:0]        rx_valid,
  output logic [N_LINKS*WORD_W-1:0] tx_word,
  output logic [N_LINKS*WORD_W-1:0] rx_out_word,
  output logic [N_LINKS-1:0]        rx_out_valid,
  output logic [N_LINKS-1:0]        link_active
);
  localparam int unsigned BUS_W = N_LINKS * WORD_W;

  logic [N_LINKS-1:0] mask_act;
  logic [N_LINKS-1:0] sync_act;
  logic [BUS_W-1:0]   tx_bus;

  for (genvar i = 0; i < N_LINKS; i++) begin : g_link
    lpg_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_stb (word_stb),
      .cfg_mask (cfg_mask[i]),
      .cfg_sync (cfg_sync[i]),
      .mask_act (mask_act[i]),
      .sync_act (sync_act[i])
    );

    lpg_tx #(.W(WORD_W), .SYNC_PAT(SYNC_PAT), .MASK_PAT(MASK_PAT)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_stb (word_stb),
      .cfg_mask (cfg_mask[i]),
      .cfg_sync (cfg_sync[i]),
      .payload  (tx_payload[i*WORD_W +: WORD_W]),
      .tx_q     (tx_bus[i*WORD_W +: WORD_W])
    );

    lpg_rx #(.W(WORD_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_act  (mask_act[i]),
      .rx_word   (rx_word[i*WORD_W +: WORD_W]),
      .rx_valid  (rx_valid[i]),
      .out_word  (rx_out_word[i*WORD_W +: WORD_W]),
      .out_valid (rx_out_valid[i])
    );
  end

  assign tx_word     = tx_bus;
  assign link_active = ~(mask_act | sync_act);
endmodule

// File: rtl/link_port_gate_chk.sv
module link_port_gate_chk #(
  parameter int unsigned N_LINKS = 11,
  parameter int unsigned WORD_W  = 16,
  parameter logic [WORD_W-1:0] SYNC_PAT = 16'h00FF,
  parameter logic [WORD_W-1:0] MASK_PAT = 16'hFF00
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      word_stb,
  input logic [N_LINKS-1:0]        cfg_mask,
  input logic [N_LINKS-1:0]        cfg_sync,
  input logic [N_LINKS-1:0]        mask_act,
  input logic [N_LINKS-1:0]        sync_act,
  input logic [N_LINKS-1:0]        rx_valid,
  input logic [N_LINKS-1:0]        rx_out_valid,
  input logic [N_LINKS*WORD_W-1:0] tx_word,
  input logic [N_LINKS-1:0]        link_active
);
  AST_CTRL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(mask_act) && $stable(sync_act)); // R2

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(tx_word)); // R7

  AST_MASK_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid & $past(mask_act)) == '0); // R3

  for (genvar i = 0; i < N_LINKS; i++) begin : g_lane
    AST_SYNC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(word_stb) && $past(cfg_sync[i])
      |-> tx_word[i*WORD_W +: WORD_W] == SYNC_PAT); // R5

    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(word_stb) && $past(cfg_mask[i]) && !$past(cfg_sync[i])
      |-> tx_word[i*WORD_W +: WORD_W] == MASK_PAT); // R6

    AST_ACTIVE_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
      link_active[i] && $past(link_active[i]) && $past(rx_valid[i])
      |-> rx_out_valid[i]); // R4
  end
endmodule

bind link_port_gate link_port_gate_chk #(
  .N_LINKS(N_LINKS), .WORD_W(WORD_W), .SYNC_PAT(SYNC_PAT), .MASK_PAT(MASK_PAT)
) u_chk (.*);

// File: tb/link_port_gate_bench.sv
module link_port_gate_bench;
  localparam int NL = 11;
  localparam int W  = 16;
  localparam logic [W-1:0] P_SYNC = 16'h00FF;
  localparam logic [W-1:0] P_MASK = 16'hFF00;
  localparam logic [NL-1:0] RXV_PAT = 11'h6DB;

  typedef struct packed {
    logic [NL-1:0] m;
    logic [NL-1:0] s;
    logic [W-1:0]  b;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{11'h000, 11'h000, 16'h1200},
    '{11'h7FF, 11'h000, 16'h3400},
    '{11'h000, 11'h7FF, 16'h5600},
    '{11'h7FF, 11'h7FF, 16'h7800},
    '{11'h555, 11'h0F0, 16'h9A00},
    '{11'h400, 11'h100, 16'hBC00},
    '{11'h000, 11'h000, 16'hDE40}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic word_stb;
  logic [NL-1:0] cfg_mask, cfg_sync, rx_valid;
  logic [NL*W-1:0] tx_payload, rx_word;
  logic [NL*W-1:0] tx_word, rx_out_word;
  logic [NL-1:0] rx_out_valid, link_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  link_port_gate u_link_port_gate (.*);

  function automatic logic [NL*W-1:0] exp_tx(logic [NL-1:0] m, logic [NL-1:0] s,
                                             logic [NL*W-1:0] pl);
    logic [NL*W-1:0] r;
    for (int i = 0; i < NL; i++)
      r[i*W +: W] = s[i] ? P_SYNC : (m[i] ? P_MASK : pl[i*W +: W]);
    return r;
  endfunction

  function automatic logic [NL*W-1:0] exp_rx(logic [NL-1:0] m, logic [NL-1:0] v,
                                             logic [NL*W-1:0] d);
    logic [NL*W-1:0] r;
    for (int i = 0; i < NL; i++)
      r[i*W +: W] = (v[i] && !m[i]) ? d[i*W +: W] : '0;
    return r;
  endfunction

  task automatic check(string req, logic [NL*W-1:0] act, logic [NL*W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [NL*W-1:0] fill(logic [W-1:0] base);
    logic [NL*W-1:0] r;
    for (int i = 0; i < NL; i++) r[i*W +: W] = base + W'(i);
    return r;
  endfunction

  // Present cfg and payload with a strobe; check tx and status after the edge.
  task automatic apply(logic [NL-1:0] m, logic [NL-1:0] s, logic [W-1:0] b);
    logic [NL*W-1:0] rxd;
    @(negedge clk);
    cfg_mask = m; cfg_sync = s; tx_payload = fill(b); word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
    check("R7/R5/R6/R9 tx lanes", tx_word, exp_tx(m, s, fill(b)));
    check("R8 status", {{(NL*W-NL){1'b0}}, link_active}, {{(NL*W-NL){1'b0}}, ~(m | s)});
    rxd = fill(b ^ 16'hA5A5);
    rx_word = rxd; rx_valid = RXV_PAT;
    @(negedge clk);
    check("R3/R4 rx valid", {{(NL*W-NL){1'b0}}, rx_out_valid},
          {{(NL*W-NL){1'b0}}, RXV_PAT & ~m});
    check("R3/R4 rx data", rx_out_word, exp_rx(m, RXV_PAT, rxd));
    rx_valid = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; word_stb = 1'b0; cfg_mask = '0; cfg_sync = '0;
    tx_payload = '0; rx_word = '0; rx_valid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rx_word = fill(16'h4444); rx_valid = '1;
    @(negedge clk);
    // R1: reset state
    check("R1 tx idle", tx_word, {NL{P_MASK}});
    check("R1 status", {{(NL*W-NL){1'b0}}, link_active}, '0);
    check("R1 rx blocked", {{(NL*W-NL){1'b0}}, rx_out_valid}, '0);
    rx_valid = '0;

    for (int k = 0; k < NV; k++) apply(VECS[k].m, VECS[k].s, VECS[k].b);

    // R2: control and payload change without a strobe has no effect
    @(negedge clk);
    cfg_mask = 11'h7FF; cfg_sync = 11'h7FF; tx_payload = fill(16'h0F0F);
    rx_word = fill(16'h2222); rx_valid = '1;
    @(negedge clk);
    @(negedge clk);
    check("R2 tx unchanged", tx_word, fill(16'hDE40));
    check("R2 status unchanged", {{(NL*W-NL){1'b0}}, link_active}, {{(NL*W-NL){1'b0}}, {NL{1'b1}}});
    check("R2 rx still open", rx_out_word, fill(16'h2222));
    rx_valid = '0;

    // R5: sync with mask on a single lane (U), others open
    apply(11'h400, 11'h400, 16'h6000);
    // R9: single lane masked (L), neighbours untouched
    apply(11'h100, 11'h000, 16'h7000);
    // R4: sync on but unmasked still forwards received words
    apply(11'h000, 11'h001, 16'h8000);

    finish_run();
  end
endmodule